// File: doc/BRIEF.md
# Synchronous Peripheral Cycle Decoder

This block sits between a CPU bus and slow on-board peripherals that follow the older synchronous, enable-clocked bus discipline. It watches the address while the address strobe is low. When the address matches the peripheral window, the block raises a valid-peripheral-address request. After the CPU answers with valid-memory-address, the block drives chip selects that are timed to a slow enable clock.

Peripheral accesses end by themselves on the falling edge of the enable clock, and the normal data-transfer acknowledge stays off for their whole length. Every other address gets the ordinary acknowledge one clock after the strobe falls. The enable clock is free-running and derived from the system clock. Each chip select belongs to one address bit, and that bit is active low.

Top module: `periph_sync_cycle`

## Requirements
- R1: `e_o` runs freely from reset with a period of 10 clocks: low for 6 clocks, then high for 4. The first clock after reset release starts a low phase.
- R2: An address is in the peripheral window when `(addr_i & 24'hFF0000) == 24'hBF0000`. If `as_ni` is low and the address is in the window, `vpa_no` goes low after the next clock edge. `vpa_no` is never low outside the window.
- R3: `dtack_no` is never low while `vpa_no` is low or while a peripheral cycle is in progress.
- R4: If `as_ni` is low and the address is outside the window, `dtack_no` goes low after the next clock edge, and `vpa_no` and all of `cs_no` stay high.
- R5: `cs_no[0]` may be low only while address bit 12 is 0 and `vma_ni` is low. `cs_no[1]` may be low only while address bit 13 is 0 and `vma_ni` is low. If `vma_ni` rises during the select phase, both chip selects go high in the same cycle.
- R6: Chip selects assert only after the request phase. If `vma_ni` is already low when the strobe falls, the chip selects stay high for the first cycle and go low one clock later.
- R7: The select phase ends on the first falling edge of `e_o` after it begins. `vpa_no` and `cs_no` return high in the cycle in which `e_o` goes low.
- R8: After a peripheral cycle has ended, no new cycle starts until `as_ni` has returned high.
- R9: While `as_ni` is high, `vpa_no`, `dtack_no` and `cs_no` are all high in that same cycle, even when the strobe is withdrawn in the middle of a cycle.
- R10: While `rst_ni` is low, all outputs are high except `e_o`, which is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | CPU address bus |
| as_ni | input | 1 | Address strobe, active low |
| vma_ni | input | 1 | Valid-memory-address from the CPU side, active low |
| e_o | output | 1 | Peripheral enable clock (system clock / 10) |
| vpa_no | output | 1 | Valid-peripheral-address request, active low |
| dtack_no | output | 1 | Normal data-transfer acknowledge, active low |
| cs_no | output | 2 | Peripheral chip selects, active low (bit 0 from A12, bit 1 from A13) |

## Verification
Two functions can act in the same cycle: the self-termination at the falling edge of the enable clock, and the qualification of the chip selects by valid-memory-address. The bench provokes this by releasing `vma_ni` in the last high clock of the enable phase and asserting it again exactly on the clock where the enable falls. The chip selects must go high in the release cycle. `vpa_no` must stay low through that cycle and then release together with the enable's fall, without a second select pulse.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SEL,
    ST_DONE,
    ST_NORM
  } pcd_state_e;
endpackage

// File: rtl/pcd_e_gen.sv
module pcd_e_gen #(
  parameter int PERIOD = 10,
  parameter int HIGH   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic e_o,
  output logic e_last_o
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam int LOW   = PERIOD - HIGH;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == CNT_W'(PERIOD - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign e_o      = (cnt_q >= CNT_W'(LOW));
  assign e_last_o = (cnt_q == CNT_W'(PERIOD - 1));

  // run-length checker for the enable phases
  logic [CNT_W:0] run_q;
  logic           e_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      e_d   <= 1'b0;
    end else begin
      e_d   <= e_o;
      run_q <= (e_o == e_d) ? run_q + 1'b1 : (CNT_W+1)'(1);
    end
  end

  a_r1_e_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_o != e_d) |-> (run_q == (e_d ? (CNT_W+1)'(HIGH) : (CNT_W+1)'(LOW))));
endmodule

// File: rtl/pcd_addr_decode.sv
module pcd_addr_decode #(
  parameter int              ADDR_W       = 24,
  parameter logic [23:0]     REGION_MASK  = 24'hFF0000,
  parameter logic [23:0]     REGION_MATCH = 24'hBF0000,
  parameter int              NUM_CS       = 2,
  parameter int              CS_BASE_BIT  = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [NUM_CS-1:0] sel_n_o
);
  assign hit_o = ((addr_i & ADDR_W'(REGION_MASK)) == ADDR_W'(REGION_MATCH));

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    assign sel_n_o[g] = addr_i[CS_BASE_BIT+g];
  end
endmodule

// File: rtl/pcd_cycle_fsm.sv
module pcd_cycle_fsm
  import pcd_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_ni,
  input  logic              vma_ni,
  input  logic              hit_i,
  input  logic              e_last_i,
  input  logic [NUM_CS-1:0] sel_n_i,
  output logic              vpa_no,
  output logic              dtack_no,
  output logic [NUM_CS-1:0] cs_no
);
  pcd_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (as_ni) st_d = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE: st_d = hit_i ? ST_REQ : ST_NORM;
        ST_REQ:  if (!vma_ni) st_d = ST_SEL;
        ST_SEL:  if (e_last_i) st_d = ST_DONE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  logic strobe;
  logic periph_act;
  assign strobe     = !as_ni;
  assign periph_act = strobe && (st_q == ST_REQ || st_q == ST_SEL);

  assign vpa_no   = !periph_act;
  assign dtack_no = !(strobe && st_q == ST_NORM);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(strobe && st_q == ST_SEL && !vma_ni && !sel_n_i[g]);
  end

  // R7: select phase leaves at the enable fall
  a_r7_end_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEL && e_last_i && !as_ni) |=> (st_q != ST_SEL));
  // R8: a finished cycle waits for strobe release
  a_r8_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE) |=> (st_q == ST_DONE || st_q == ST_IDLE));
  // R6: select only after request
  a_r6_sel_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEL) |-> ($past(st_q) == ST_REQ || $past(st_q) == ST_SEL));
endmodule

// File: rtl/periph_sync_cycle.sv
module periph_sync_cycle #(
  parameter int          ADDR_W       = 24,
  parameter logic [23:0] REGION_MASK  = 24'hFF0000,
  parameter logic [23:0] REGION_MATCH = 24'hBF0000,
  parameter int          NUM_CS       = 2,
  parameter int          CS_BASE_BIT  = 12,
  parameter int          E_PERIOD     = 10,
  parameter int          E_HIGH       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              as_ni,
  input  logic              vma_ni,
  output logic              e_o,
  output logic              vpa_no,
  output logic              dtack_no,
  output logic [NUM_CS-1:0] cs_no
);
  logic              hit;
  logic              e_last;
  logic [NUM_CS-1:0] sel_n;

  pcd_e_gen #(.PERIOD(E_PERIOD), .HIGH(E_HIGH)) u_e_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .e_o      (e_o),
    .e_last_o (e_last)
  );

  pcd_addr_decode #(
    .ADDR_W(ADDR_W), .REGION_MASK(REGION_MASK), .REGION_MATCH(REGION_MATCH),
    .NUM_CS(NUM_CS), .CS_BASE_BIT(CS_BASE_BIT)
  ) u_dec (
    .addr_i  (addr_i),
    .hit_o   (hit),
    .sel_n_o (sel_n)
  );

  pcd_cycle_fsm #(.NUM_CS(NUM_CS)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .as_ni    (as_ni),
    .vma_ni   (vma_ni),
    .hit_i    (hit),
    .e_last_i (e_last),
    .sel_n_i  (sel_n),
    .vpa_no   (vpa_no),
    .dtack_no (dtack_no),
    .cs_no    (cs_no)
  );

  a_r3_no_dtack_periph: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpa_no |-> dtack_no);
  a_r9_strobe_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |-> (vpa_no && dtack_no && (&cs_no)));
  a_r2_vpa_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpa_no |-> ((addr_i & ADDR_W'(REGION_MASK)) == ADDR_W'(REGION_MATCH)));

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs_chk
    a_r5_cs_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_no[g] |-> (!vma_ni && !addr_i[CS_BASE_BIT+g]));
  end
endmodule

// File: tb/periph_sync_cycle_tb.sv
module periph_sync_cycle_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] addr;
  logic        as_n, vma_n;
  logic        e, vpa_n, dtack_n;
  logic [1:0]  cs_n;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  periph_sync_cycle u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .as_ni(as_n),
    .vma_ni(vma_n), .e_o(e), .vpa_no(vpa_n), .dtack_no(dtack_n), .cs_no(cs_n)
  );

  // {as_n, vma_n, hit, a13, a12, exp_e, exp_vpa_n, exp_dtack_n, exp_cs1_n, exp_cs0_n}
  localparam int NV = 23;
  localparam logic [9:0] VEC [NV] = '{
    10'b1_1_0_1_1_0_1_1_11,  // idle
    10'b0_1_0_1_1_0_1_0_11,  // R4 normal cycle ack
    10'b0_1_0_1_1_0_1_0_11,
    10'b1_1_0_1_1_0_1_1_11,
    10'b0_1_1_1_0_0_0_1_11,  // R2 request
    10'b0_1_1_1_0_1_0_1_11,
    10'b0_0_1_1_0_1_0_1_10,  // R5 cs0 via A12
    10'b0_0_1_1_0_1_0_1_10,
    10'b0_0_1_1_0_1_0_1_10,
    10'b0_0_1_1_0_0_1_1_11,  // R7 ends on E fall
    10'b0_0_1_1_0_0_1_1_11,  // R8 no restart
    10'b1_1_1_1_0_0_1_1_11,
    10'b0_1_1_0_1_0_0_1_11,
    10'b0_0_1_0_1_0_0_1_01,  // R5 cs1 via A13
    10'b1_0_1_0_1_0_1_1_11,  // R9 early strobe removal
    10'b0_0_1_0_0_1_0_1_11,  // R6 vma early, no cs yet
    10'b0_0_1_0_0_1_0_1_00,
    10'b0_0_1_0_0_1_0_1_00,
    10'b0_1_1_0_0_1_0_1_11,  // R5 vma release drops cs
    10'b0_0_1_0_0_0_1_1_11,  // R7 termination coincides with vma return
    10'b1_0_1_0_0_0_1_1_11,
    10'b0_0_0_0_0_0_1_0_11,  // R4 outside window, no cs
    10'b1_0_0_0_0_0_1_1_11
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [9:0] v);
    as_n  = v[9];
    vma_n = v[8];
    addr  = {(v[7] ? 8'hBF : 8'h20), 2'b00, v[6], v[5], 12'h001};
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    // R10: outputs inactive while in reset, even with an active request
    drive(10'b0_0_1_0_0_0_0_0_00);
    repeat (3) @(negedge clk);
    chk("R10 vpa/dtack", {vpa_n, dtack_n}, 2'b11);
    chk("R10 cs", cs_n, 2'b11);
    chk("R10 e", {1'b0, e}, 2'b00);

    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      chk("R1 e", {1'b0, e}, {1'b0, VEC[i][4]});
      chk("R2 vpa", {1'b0, vpa_n}, {1'b0, VEC[i][3]});
      chk("R3/R4 dtack", {1'b0, dtack_n}, {1'b0, VEC[i][2]});
      chk("R5/R6 cs", cs_n, VEC[i][1:0]);
    end

    // R9: strobe withdrawn mid-select clears outputs in the same cycle
    drive(10'b0_0_1_1_0_0_0_0_00);
    @(negedge clk);
    @(negedge clk);
    chk("R9 pre cs", cs_n, 2'b10);
    as_n = 1'b1;
    #1;
    chk("R9 vpa/dtack", {vpa_n, dtack_n}, 2'b11);
    chk("R9 cs", cs_n, 2'b11);

    // R10: reset asserted during a request
    @(negedge clk);
    drive(10'b0_0_1_0_0_0_0_0_00);
    @(negedge clk);
    chk("R10 pre vpa", {1'b0, vpa_n}, 2'b00);
    rst_ni = 1'b0;
    #1;
    chk("R10 mid vpa/dtack", {vpa_n, dtack_n}, 2'b11);
    chk("R10 mid cs", cs_n, 2'b11);
    chk("R10 mid e", {1'b0, e}, 2'b00);

    done = 1'b1;
    summary();
  end
endmodule